// File: doc/BRIEF.md
# Carry-Save Redundant Adder Unit

This functional unit sums between three and six operand words and returns the result in redundant form: a carry word and a sum word whose modular total is the answer. No carry ever ripples across the word. The caller groups its operands into plain binary words and (carry, sum) pairs. One of four kinds of add is selected, so that three, four, five or six words are compressed. A subtract flag negates the last pair of the operand list instead of adding it. Resolving the pair into one binary number is left to whatever consumes it.

Operands enter through a valid/ready handshake. The compressed pair is captured in an output register and offered on a second valid/ready handshake. A new operation is taken whenever that register is empty or is being emptied in the same cycle. This gives one operation per clock at full throughput, with one cycle of latency.

Top module: `rcs_add_unit`

## Requirements
- R1: With op_i = 3'b000, only words 0..2 are used, and (carry_o + sum_o) mod 2^W equals w0 + w1 + w2 + cin_i mod 2^W. This covers three plain words, or one plain word plus a pair in words 1 and 2.
- R2: With op_i = 3'b001, words 0..3 (two pairs) are used, and the pair total equals w0 + w1 + w2 + w3 + cin_i mod 2^W.
- R3: With op_i = 3'b010, words 0..4 (a plain word plus two pairs) are used, and the pair total equals the sum of those five words plus cin_i mod 2^W.
- R4: With op_i = 3'b011, all six words (three pairs) are used, and the pair total equals their sum plus cin_i mod 2^W.
- R5: Setting op_i[2] subtracts the last two used words instead of adding them. For n used words, the total is w0 + ... + w(n-3) - w(n-2) - w(n-1) + cin_i mod 2^W.
- R6: Words with index at or above the count used by op_i[1:0] have no effect on the result, whatever their value.
- R7: cin_i adds exactly one to the pair total for every kind of operation.
- R8: While rst_n is low, out_valid_o is 0, carry_o and sum_o are 0, and in_ready_o is 1.
- R9: While out_valid_o is 1 and out_ready_i is 0, carry_o and sum_o hold their value and out_valid_o stays 1.
- R10: in_ready_o is 1 exactly when the output register is empty or out_ready_i is 1. An input accepted in one cycle appears with out_valid_o = 1 after the next rising edge.
- R11: When a result is taken (out_valid_o and out_ready_i both 1) and no input is accepted in the same cycle, out_valid_o is 0 after the edge.
- R12: All arithmetic wraps modulo 2^W. Carries out of the top bit are discarded, and results that go negative wrap to the high end of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Bits 1:0 give the operation kind (3, 4, 5 or 6 words); bit 2 selects subtract |
| opd_i | input | 6×W | Operand words; word k sits in bits k*W+W-1 : k*W |
| cin_i | input | 1 | Carry-in added to the total |
| in_valid_i | input | 1 | Operands offered |
| in_ready_o | output | 1 | Unit can take the offered operands |
| out_valid_o | output | 1 | Result pair available |
| out_ready_i | input | 1 | Consumer takes the result pair |
| carry_o | output | W | Carry word of the redundant result |
| sum_o | output | W | Sum word of the redundant result |

## Verification
The bench fills the unused operand words with all-ones and random garbage. A unit that forgot to clear them would return totals shifted by those words. Subtraction is checked in every kind, including a result that goes below zero. A unit that dropped one of the two negation corrections would be off by one or two, and one that negated the wrong words would give an unrelated total. Long stretches of held ready test that the pair stays frozen. Ready toggling against a bursty input tests the same-cycle drain-and-refill case: there, a unit that refused the new input would lose throughput, and one that cleared the register would lose a result.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   localparam int NUM_WORDS = 6;

   typedef enum logic [1:0] {
      KIND_W3 = 2'd0,
      KIND_W4 = 2'd1,
      KIND_W5 = 2'd2,
      KIND_W6 = 2'd3
   } rcs_kind_e;

   function automatic int words_used(input rcs_kind_e kind);
      case (kind)
         KIND_W3: return 3;
         KIND_W4: return 4;
         KIND_W5: return 5;
         default: return 6;
      endcase
   endfunction

endpackage

// File: rtl/rcs_operand_prep.sv
module rcs_operand_prep import rcs_pkg::*; #(
   parameter int W = 16
) (
   input  logic [2:0]                  op_i,
   input  logic [NUM_WORDS-1:0][W-1:0] opd_i,
   output logic [NUM_WORDS-1:0][W-1:0] word_o,
   output logic                        sub_o
);

   rcs_kind_e kind;
   int        nused;

   assign kind  = rcs_kind_e'(op_i[1:0]);
   assign nused = words_used(kind);
   assign sub_o = op_i[2];

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      logic used;
      logic negate;
      assign used   = (g < nused);
      assign negate = sub_o && (g >= nused - 2);
      always_comb begin
         if (!used)
            word_o[g] = '0;
         else if (negate)
            word_o[g] = ~opd_i[g];
         else
            word_o[g] = opd_i[g];
      end
   end

endmodule

// File: rtl/rcs_csa32.sv
module rcs_csa32 #(
   parameter int W = 16
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   input  logic         inj_i,
   output logic [W-1:0] s_o,
   output logic [W-1:0] c_o
);

   assign c_o[0] = inj_i;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign s_o[b] = x_i[b] ^ y_i[b] ^ z_i[b];
      if (b < W - 1) begin : g_carry
         assign c_o[b+1] = (x_i[b] & y_i[b]) | (x_i[b] & z_i[b]) | (y_i[b] & z_i[b]);
      end
   end

endmodule

// File: rtl/rcs_tree6.sv
module rcs_tree6 import rcs_pkg::*; #(
   parameter int W = 16
) (
   input  logic [NUM_WORDS-1:0][W-1:0] word_i,
   input  logic                        cin_i,
   input  logic                        corr_i,
   output logic [W-1:0]                carry_o,
   output logic [W-1:0]                sum_o
);

   logic [W-1:0] s_a, c_a, s_b, c_b, s_c, c_c;

   rcs_csa32 #(.W(W)) u_lvl1_lo (
      .x_i(word_i[0]), .y_i(word_i[1]), .z_i(word_i[2]),
      .inj_i(cin_i), .s_o(s_a), .c_o(c_a)
   );

   rcs_csa32 #(.W(W)) u_lvl1_hi (
      .x_i(word_i[3]), .y_i(word_i[4]), .z_i(word_i[5]),
      .inj_i(corr_i), .s_o(s_b), .c_o(c_b)
   );

   rcs_csa32 #(.W(W)) u_lvl2 (
      .x_i(s_a), .y_i(c_a), .z_i(s_b),
      .inj_i(corr_i), .s_o(s_c), .c_o(c_c)
   );

   rcs_csa32 #(.W(W)) u_lvl3 (
      .x_i(s_c), .y_i(c_c), .z_i(c_b),
      .inj_i(1'b0), .s_o(sum_o), .c_o(carry_o)
   );

endmodule

// File: rtl/rcs_add_unit.sv
module rcs_add_unit import rcs_pkg::*; #(
   parameter int W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  op_i,
   input  logic [NUM_WORDS-1:0][W-1:0] opd_i,
   input  logic                        cin_i,
   input  logic                        in_valid_i,
   output logic                        in_ready_o,
   output logic                        out_valid_o,
   input  logic                        out_ready_i,
   output logic [W-1:0]                carry_o,
   output logic [W-1:0]                sum_o
);

   if (W < 2) begin : g_bad_width
      $error("rcs_add_unit: W must be at least 2");
   end

   logic [NUM_WORDS-1:0][W-1:0] prep_words;
   logic                        sub_flag;
   logic [W-1:0]                nxt_carry, nxt_sum;
   logic                        take;

   rcs_operand_prep #(.W(W)) u_prep (
      .op_i(op_i), .opd_i(opd_i), .word_o(prep_words), .sub_o(sub_flag)
   );

   rcs_tree6 #(.W(W)) u_tree (
      .word_i(prep_words), .cin_i(cin_i), .corr_i(sub_flag),
      .carry_o(nxt_carry), .sum_o(nxt_sum)
   );

   assign in_ready_o = !out_valid_o || out_ready_i;
   assign take       = in_valid_i && in_ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         carry_o     <= '0;
         sum_o       <= '0;
      end else if (take) begin
         out_valid_o <= 1'b1;
         carry_o     <= nxt_carry;
         sum_o       <= nxt_sum;
      end else if (out_ready_i) begin
         out_valid_o <= 1'b0;
      end
   end

   // Behavioural total of the offered operands, used only by the checks below.
   logic [W-1:0] chk_total;
   int           chk_n;
   assign chk_n = 3 + int'(op_i[1:0]);
   always_comb begin
      chk_total = W'(cin_i);
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (i < chk_n) begin
            if (op_i[2] && (i >= chk_n - 2))
               chk_total = chk_total - opd_i[i];
            else
               chk_total = chk_total + opd_i[i];
         end
      end
   end

   AST_PAIR_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (W'(carry_o + sum_o) == $past(chk_total)));                       // R1

   AST_LOAD_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid_o);                                                     // R10

   AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(carry_o) && $stable(sum_o))); // R9

   AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);             // R11

endmodule

// File: tb/rcs_add_unit_bench.sv
`timescale 1ns/1ps
module rcs_add_unit_bench;
   import rcs_pkg::*;

   localparam int W   = 16;
   localparam int NTX = 400;

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic [2:0]                  op = '0;
   logic [NUM_WORDS-1:0][W-1:0] words = '0;
   logic                        cin = 1'b0;
   logic                        in_valid = 1'b0;
   logic                        in_ready;
   logic                        out_valid;
   logic                        out_ready = 1'b1;
   logic [W-1:0]                carry_w, sum_w;

   int    n_checks = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #4 clk = ~clk;

   rcs_add_unit #(.W(W)) u_rcs_add_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op), .opd_i(words), .cin_i(cin),
      .in_valid_i(in_valid), .in_ready_o(in_ready), .out_valid_o(out_valid),
      .out_ready_i(out_ready), .carry_o(carry_w), .sum_o(sum_w)
   );

   function automatic logic [W-1:0] bench_ref(input logic [2:0] o,
                                              input logic [NUM_WORDS-1:0][W-1:0] w,
                                              input logic c);
      int n = 3 + int'(o[1:0]);
      logic [W-1:0] t = W'(c);
      for (int i = 0; i < n; i++) begin
         if (o[2] && i >= n - 2) t = t - w[i];
         else                   t = t + w[i];
      end
      return t;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // reference model state
   bit           m_valid = 1'b0;
   logic [W-1:0] m_exp = '0;
   string        m_tag = "R1";
   bit           last_acc = 1'b0;
   string        cur_tag = "R1";
   bit           prev_stall = 1'b0;
   logic [W-1:0] prev_c = '0, prev_s = '0;
   int           t = 0;
   int           cyc = 0;

   task automatic gen(input int idx);
      logic [NUM_WORDS-1:0][W-1:0] w;
      for (int i = 0; i < NUM_WORDS; i++) w[i] = W'($urandom);
      cin = 1'b0;
      case (idx)
         0:  begin op = 3'b000; w[0] = 16'd5; w[1] = 16'd7; w[2] = 16'd9; cur_tag = "R1"; end
         1:  begin op = 3'b001; cur_tag = "R2"; end
         2:  begin op = 3'b010; cur_tag = "R3"; end
         3:  begin op = 3'b011; cur_tag = "R4"; end
         4:  begin op = 3'b100; cur_tag = "R5"; end
         5:  begin op = 3'b101; cur_tag = "R5"; end
         6:  begin op = 3'b110; cur_tag = "R5"; end
         7:  begin op = 3'b111; cur_tag = "R5"; end
         8:  begin op = 3'b000; w[0] = '0; w[1] = '0; w[2] = '0;
                   w[3] = '1; w[4] = '1; w[5] = '1; cur_tag = "R6"; end
         9:  begin op = 3'b001; w = '1; cin = 1'b1; cur_tag = "R12"; end
         10: begin op = 3'b011; w = '0; cin = 1'b1; cur_tag = "R7"; end
         11: begin op = 3'b111; w = '0; w[4] = 16'd1; cur_tag = "R12"; end
         default: begin
            op  = 3'($urandom);
            cin = 1'($urandom);
            if (op[2]) cur_tag = "R5";
            else case (op[1:0])
               2'd0: cur_tag = "R1";
               2'd1: cur_tag = "R2";
               2'd2: cur_tag = "R3";
               default: cur_tag = "R4";
            endcase
         end
      endcase
      words = w;
   endtask

   initial begin
      // reset phase (R8)
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", W'(out_valid), '0);
      chk(carry_w == '0, "R8", carry_w, '0);
      chk(sum_w == '0, "R8", sum_w, '0);
      chk(in_ready == 1'b1, "R8", W'(in_ready), W'(1));
      rst_n = 1'b1;
      while (!(t >= NTX && !in_valid && cyc > 20)) begin
         @(posedge clk);
         // model step
         last_acc = in_valid && (!m_valid || out_ready);
         if (last_acc) begin
            m_valid = 1'b1;
            m_exp   = bench_ref(op, words, cin);
            m_tag   = cur_tag;
         end else if (out_ready) begin
            m_valid = 1'b0;
         end
         @(negedge clk);
         cyc++;
         // checks
         chk(out_valid == m_valid, m_valid ? "R10" : "R11", W'(out_valid), W'(m_valid));
         chk(in_ready == (!m_valid || out_ready), "R10", W'(in_ready), W'(!m_valid || out_ready));
         if (m_valid && out_valid)
            chk(W'(carry_w + sum_w) == m_exp, m_tag, W'(carry_w + sum_w), m_exp);
         if (prev_stall) begin
            chk(carry_w == prev_c, "R9", carry_w, prev_c);
            chk(sum_w == prev_s, "R9", sum_w, prev_s);
         end
         // drive next
         if (cyc < 30)       out_ready = 1'b1;
         else if (cyc < 120) out_ready = (cyc % 3) != 0;
         else                out_ready = 1'($urandom);
         if (!in_valid || last_acc) begin
            if (t < NTX) begin
               if (t >= 12 && $urandom_range(3) == 0) in_valid = 1'b0;
               else begin
                  gen(t);
                  in_valid = 1'b1;
                  t++;
               end
            end else begin
               in_valid = 1'b0;
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_c = carry_w;
         prev_s = sum_w;
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
         $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule